// File: doc/BRIEF.md
# Programmable-Length Serial Frame Shifter

This block moves one serial frame at a time between an 8-bit parallel shift register and a serial data line. The serial clock is generated elsewhere. The block receives it as a level plus separate rise and fall strobes, all already synchronized to the system clock. A small count field selects how many data bits the next frame carries, from 1 to 8. A format input selects one of two modes. The two-wire bus mode adds one acknowledge slot after the data bits. The plain clocked synchronous mode has no acknowledge slot.

Software sets the frame up through three write ports: a control byte, the count field and the data byte. It then watches the interrupt flag. At the end of every frame the block sets the flag and returns the count field to zero. The flag stays set until software writes a 0 to it. The block also watches the bus for start and stop conditions. A start restarts the frame position, clears the count and sets a bus-busy status bit. A stop clears bus-busy.

Top module: `serial_frame_shifter`

## Requirements
- R1: After reset, `ctrlRd` reads 8'h01, `cntRd` reads 0, `sdaOut` is 1 (released) and `irq` is 0.
- R2: A frame has N data slots, where N is the count field, and a count of 0 means 8. In bus mode (`fmtSync`=0) one acknowledge slot follows the data slots. A frame ends on the SCL fall strobe of its last slot, and no earlier.
- R3: When a frame ends, the count field (`cntRd`) returns to 0 and the interrupt flag (`ctrlRd` bit 1) is set.
- R4: A start condition is SDA falling while SCL is high. It clears the count field, returns the frame to its first slot and sets bus-busy (`ctrlRd` bit 2). A stop condition is SDA rising while SCL is high. It clears bus-busy and returns the frame to its first slot.
- R5: A count write takes effect only between frames. A nonzero value is accepted only while SCL is low. A write at any other time leaves `cntRd` unchanged.
- R6: Writing 0 to `ctrlRd` bit 1 clears the interrupt flag, and writing 1 to it leaves the flag as it was. `irq` is 1 exactly when the flag and irq-enable (`ctrlRd` bit 6) are both 1.
- R7: With transmit (`ctrlRd` bit 4) set, the data goes out MSB first on `sdaOut`. The output moves to the next bit only after an SCL fall strobe. After a frame of N bits, `dataRd` holds the original byte shifted left by N.
- R8: With transmit clear, the block samples `sdaIn` on each SCL rise strobe in a data slot and shifts it into the LSB. After N bits, `dataRd` holds the old byte shifted left by N, with the received bits in the low N positions, MSB first.
- R9: When receiving in bus mode with ack-enable (`ctrlRd` bit 3) at 0, `sdaOut` is 0 during the acknowledge slot. With ack-enable at 1, `sdaOut` stays 1.
- R10: When transmitting in bus mode, the level of `sdaIn` at the rise strobe of the acknowledge slot appears on `ackSeen`.
- R11: With enable (`ctrlRd` bit 7) at 0, the SCL strobes change neither the count field nor `dataRd`, and `sdaOut` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclRise | input | 1 | One-cycle strobe on a rising SCL edge |
| sclFall | input | 1 | One-cycle strobe on a falling SCL edge |
| sclLevel | input | 1 | Synchronized SCL level |
| sdaIn | input | 1 | Synchronized SDA line level |
| fmtSync | input | 1 | 1 = synchronous format, 0 = bus format with acknowledge |
| ctrlWrEn | input | 1 | Control byte write strobe |
| ctrlWrData | input | 8 | Control byte: 7 enable, 6 irq-enable, 5 master, 4 transmit, 3 ack-enable, 1 flag clear-by-0 |
| cntWrEn | input | 1 | Count field write strobe |
| cntWrData | input | 3 | Count field value, 0 means 8 |
| dataWrEn | input | 1 | Data byte write strobe, accepted between frames |
| dataWrData | input | 8 | Data byte to load |
| sdaOut | output | 1 | Drive for SDA, 0 pulls low and 1 releases |
| ctrlRd | output | 8 | Control/status byte, with bit 2 busy, bit 1 flag and bit 0 always 1 |
| cntRd | output | 3 | Current count field |
| dataRd | output | 8 | Shift register contents |
| ackSeen | output | 1 | Acknowledge level captured while transmitting |
| irq | output | 1 | Interrupt request |

## Verification
Every register sits one system clock behind its strobe. A change caused by a write, an SCL strobe or an SDA edge is therefore visible on the ports at the falling clock edge after the rising edge that took in the stimulus. `sdaOut` follows the internal state through logic only, so it also settles in that cycle. The bench drives all inputs at a falling edge, holds each strobe for exactly one cycle and samples one full cycle later. It checks the count and the flag both before and after the last SCL fall strobe, which proves that a frame ends on that strobe and not one slot early or late.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  // strobes from the sequencing control into the shift datapath
  typedef struct packed {
    logic loadData;
    logic shiftIn;
    logic shiftOut;
    logic captureAck;
    logic driveData;
    logic driveAck;
  } sfsStrobe_t;

  // control byte field positions (software-visible layout)
  localparam int CTL_EN    = 7;
  localparam int CTL_IRQEN = 6;
  localparam int CTL_MST   = 5;
  localparam int CTL_TX    = 4;
  localparam int CTL_ACKEN = 3;
  localparam int CTL_BUSY  = 2;
  localparam int CTL_FLAG  = 1;
endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W),
  parameter int SLOT_W = $clog2(DATA_W + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             sclLevel,
  input  logic             sdaIn,
  input  logic             fmtSync,
  input  logic             ctrlWrEn,
  input  logic [7:0]       ctrlWrData,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             dataWrEn,
  output logic [7:0]       ctrlRd,
  output logic [CNT_W-1:0] cntRd,
  output logic             irq,
  output sfsStrobe_t       strb
);
  localparam logic [SLOT_W-1:0] FULL_LEN = SLOT_W'(DATA_W);
  localparam logic [SLOT_W-1:0] ONE      = SLOT_W'(1);

  logic             enable, irqEnable, master, transmit, ackEnable;
  logic             busy, irqFlag, sdaPrev, sampled;
  logic [CNT_W-1:0] cntField;
  logic [SLOT_W-1:0] slot, dataBits, frameLen;
  logic             idle, startDet, stopDet, active, riseEv, fallEv, frameEnd;
  logic             inData, inAck, cntAccept;
  logic             unusedWr;

  assign unusedWr = ctrlWrData[CTL_BUSY] ^ ctrlWrData[0];

  // frame geometry derived from the count field and the format
  assign dataBits = (cntField == '0) ? FULL_LEN
                                     : {{(SLOT_W-CNT_W){1'b0}}, cntField};
  assign frameLen = dataBits + {{(SLOT_W-1){1'b0}}, ~fmtSync};
  assign inData   = slot < dataBits;
  assign inAck    = ~fmtSync && (slot == dataBits);
  assign idle     = (slot == '0) && ~sampled;

  // bus condition detection: SDA edge while SCL is high
  assign startDet = enable && sclLevel && sdaPrev && ~sdaIn;
  assign stopDet  = enable && sclLevel && ~sdaPrev && sdaIn;
  assign active   = enable && ~startDet && ~stopDet;
  assign riseEv   = active && sclRise;
  assign fallEv   = active && sclFall && sampled;
  assign frameEnd = fallEv && (slot == frameLen - ONE);

  assign cntAccept = cntWrEn && idle && ((cntWrData == '0) || ~sclLevel);

  always_comb begin
    strb            = '0;
    strb.loadData   = dataWrEn && idle;
    strb.shiftIn    = riseEv && inData && ~transmit;
    strb.captureAck = riseEv && inAck && transmit;
    strb.shiftOut   = fallEv && inData && transmit;
    strb.driveData  = enable && transmit && inData;
    strb.driveAck   = enable && ~transmit && inAck && ~ackEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaPrev <= 1'b1;
    end else begin
      sdaPrev <= sdaIn;
    end
  end

  // slot position within the frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot    <= '0;
      sampled <= 1'b0;
    end else if (startDet || stopDet || frameEnd) begin
      slot    <= '0;
      sampled <= 1'b0;
    end else if (fallEv) begin
      slot    <= slot + ONE;
      sampled <= 1'b0;
    end else if (riseEv) begin
      sampled <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntField <= '0;
    end else if (startDet || frameEnd) begin
      cntField <= '0;
    end else if (cntAccept) begin
      cntField <= cntWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (startDet) begin
      busy <= 1'b1;
    end else if (stopDet) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (frameEnd) begin
      irqFlag <= 1'b1;
    end else if (ctrlWrEn && !ctrlWrData[CTL_FLAG]) begin
      irqFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      irqEnable <= 1'b0;
      master    <= 1'b0;
      transmit  <= 1'b0;
      ackEnable <= 1'b0;
    end else if (ctrlWrEn) begin
      enable    <= ctrlWrData[CTL_EN];
      irqEnable <= ctrlWrData[CTL_IRQEN];
      master    <= ctrlWrData[CTL_MST];
      transmit  <= ctrlWrData[CTL_TX];
      ackEnable <= ctrlWrData[CTL_ACKEN];
    end
  end

  assign ctrlRd = {enable, irqEnable, master, transmit, ackEnable, busy, irqFlag, 1'b1};
  assign cntRd  = cntField;
  assign irq    = irqFlag && irqEnable;
endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] dataWrData,
  input  sfsStrobe_t        strb,
  output logic [DATA_W-1:0] dataRd,
  output logic              ackSeen,
  output logic              sdaOut
);
  logic [DATA_W-1:0] shReg;
  logic              ackBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.loadData) begin
      shReg <= dataWrData;
    end else if (strb.shiftIn) begin
      shReg <= {shReg[DATA_W-2:0], sdaIn};
    end else if (strb.shiftOut) begin
      shReg <= {shReg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackBit <= 1'b1;
    end else if (strb.captureAck) begin
      ackBit <= sdaIn;
    end
  end

  always_comb begin
    if (strb.driveData) begin
      sdaOut = shReg[DATA_W-1];
    end else if (strb.driveAck) begin
      sdaOut = 1'b0;
    end else begin
      sdaOut = 1'b1;
    end
  end

  assign dataRd  = shReg;
  assign ackSeen = ackBit;
endmodule

// File: rtl/serial_frame_shifter.sv
module serial_frame_shifter
  import sfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sclLevel,
  input  logic              sdaIn,
  input  logic              fmtSync,
  input  logic              ctrlWrEn,
  input  logic [7:0]        ctrlWrData,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic              dataWrEn,
  input  logic [DATA_W-1:0] dataWrData,
  output logic              sdaOut,
  output logic [7:0]        ctrlRd,
  output logic [CNT_W-1:0]  cntRd,
  output logic [DATA_W-1:0] dataRd,
  output logic              ackSeen,
  output logic              irq
);
  sfsStrobe_t strb;

  sfs_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .sclLevel(sclLevel), .sdaIn(sdaIn), .fmtSync(fmtSync),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .dataWrEn(dataWrEn),
    .ctrlRd(ctrlRd), .cntRd(cntRd), .irq(irq), .strb(strb)
  );

  sfs_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .dataWrData(dataWrData),
    .strb(strb), .dataRd(dataRd), .ackSeen(ackSeen), .sdaOut(sdaOut)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclFall,
  input logic              sclLevel,
  input logic              sdaIn,
  input logic              ctrlWrEn,
  input logic [7:0]        ctrlWrData,
  input logic              cntWrEn,
  input logic [CNT_W-1:0]  cntWrData,
  input logic              dataWrEn,
  input logic              sdaOut,
  input logic [7:0]        ctrlRd,
  input logic [CNT_W-1:0]  cntRd,
  input logic [DATA_W-1:0] dataRd
);
  logic chkSdaPrev, sdaDrop, sdaLift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkSdaPrev <= 1'b1;
    else       chkSdaPrev <= sdaIn;
  end

  assign sdaDrop = sclLevel && chkSdaPrev && !sdaIn;
  assign sdaLift = sclLevel && !chkSdaPrev && sdaIn;

  // R3: the flag only rises at a frame end, and the count is zero then
  p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlRd[1]) |-> (cntRd == '0));

  // R4: a start condition clears the count and raises busy
  p_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[7] && sdaDrop) |=> ((cntRd == '0) && ctrlRd[2]));

  // R5: a nonzero count write while SCL is high is dropped
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrEn && (cntWrData != '0) && sclLevel && !sdaDrop && !sclFall)
      |=> $stable(cntRd));

  // R6: a set flag survives any control write that does not write 0 to it
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[1] && !(ctrlWrEn && !ctrlWrData[1])) |=> ctrlRd[1]);

  // R7: transmit output moves only after a fall strobe
  p_tx_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[7] && ctrlRd[4] && !sclFall && !ctrlWrEn && !dataWrEn
     && !sdaDrop && !sdaLift) |=> $stable(sdaOut));

  // R11: a disabled block holds its count, data and busy state
  p_disabled_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRd[7] && !ctrlWrEn && !dataWrEn && !cntWrEn)
      |=> ($stable(cntRd) && $stable(dataRd) && $stable(ctrlRd[2])));
endmodule

bind serial_frame_shifter sfs_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclFall(sclFall), .sclLevel(sclLevel),
  .sdaIn(sdaIn), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
  .cntWrEn(cntWrEn), .cntWrData(cntWrData), .dataWrEn(dataWrEn),
  .sdaOut(sdaOut), .ctrlRd(ctrlRd), .cntRd(cntRd), .dataRd(dataRd)
);

// File: tb/serial_frame_shifter_tb_top.sv
`timescale 1ns/1ps
module serial_frame_shifter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclRise = 1'b0, sclFall = 1'b0, sclLevel = 1'b1, sdaIn = 1'b1;
  logic       fmtSync = 1'b0;
  logic       ctrlWrEn = 1'b0, cntWrEn = 1'b0, dataWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0, dataWrData = '0;
  logic [2:0] cntWrData = '0;
  logic       sdaOut, ackSeen, irq;
  logic [7:0] ctrlRd, dataRd;
  logic [2:0] cntRd;
  int         checks = 0, fails = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  serial_frame_shifter dut_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .sclLevel(sclLevel), .sdaIn(sdaIn), .fmtSync(fmtSync),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .cntWrEn(cntWrEn),
    .cntWrData(cntWrData), .dataWrEn(dataWrEn), .dataWrData(dataWrData),
    .sdaOut(sdaOut), .ctrlRd(ctrlRd), .cntRd(cntRd), .dataRd(dataRd),
    .ackSeen(ackSeen), .irq(irq)
  );

  // vector: fmt, cnt, tx, ackEn, data, rx pattern (MSB first), ack level driven
  typedef struct packed {
    logic       fmt;
    logic [2:0] cnt;
    logic       tx;
    logic       ackEn;
    logic [7:0] data;
    logic [7:0] rxPat;
    logic       ackIn;
  } vec_t;

  localparam int NVEC = 6;
  localparam logic [22:0] VECS [NVEC] = '{
    {1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 8'hB3, 1'b1},
    {1'b0, 3'd3, 1'b0, 1'b1, 8'h00, 8'hA0, 1'b1},
    {1'b1, 3'd5, 1'b0, 1'b0, 8'h00, 8'hD0, 1'b1},
    {1'b0, 3'd0, 1'b1, 1'b0, 8'hA5, 8'h00, 1'b0},
    {1'b1, 3'd1, 1'b1, 1'b0, 8'h80, 8'h00, 1'b1},
    {1'b0, 3'd7, 1'b1, 1'b0, 8'h3C, 8'h00, 1'b1}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulseRise();
    sclLevel = 1'b1; sclRise = 1'b1; tick();
    sclRise = 1'b0; tick();
  endtask

  task automatic pulseFall();
    sclLevel = 1'b0; sclFall = 1'b1; tick();
    sclFall = 1'b0; tick();
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    ctrlWrData = d; ctrlWrEn = 1'b1; tick();
    ctrlWrEn = 1'b0; tick();
  endtask

  task automatic wrCnt(input logic [2:0] d);
    cntWrData = d; cntWrEn = 1'b1; tick();
    cntWrEn = 1'b0; tick();
  endtask

  task automatic wrData(input logic [7:0] d);
    dataWrData = d; dataWrEn = 1'b1; tick();
    dataWrEn = 1'b0; tick();
  endtask

  // leaves SCL low after the start condition
  task automatic doStart();
    if (!sclLevel) begin
      sdaIn = 1'b1; tick();
      pulseRise();
    end
    sdaIn = 1'b0; tick(); tick();
    pulseFall();
  endtask

  // leaves SCL and SDA high
  task automatic doStop();
    if (!sclLevel) begin
      sdaIn = 1'b0; tick();
      pulseRise();
    end
    sdaIn = 1'b1; tick(); tick();
  endtask

  task automatic runVec(input vec_t v);
    int n, len, outErr, expData;
    logic expBit;
    n   = (v.cnt == 3'd0) ? 8 : int'(v.cnt);
    len = n + (v.fmt ? 0 : 1);
    outErr = 0;
    wrCtrl(8'hC0 | (8'(v.tx) << 4) | (8'(v.ackEn) << 3));
    fmtSync = v.fmt;
    doStart();
    wrCnt(v.cnt);
    wrData(v.data);
    for (int s = 0; s < len; s++) begin
      if (s < n) sdaIn = v.tx ? 1'b1 : v.rxPat[7-s];
      else       sdaIn = v.ackIn;
      tick();
      if (s < n && v.tx)                   expBit = v.data[7-s];
      else if (s == n && !v.tx && !v.ackEn) expBit = 1'b0;
      else                                 expBit = 1'b1;
      if (sdaOut !== expBit) outErr++;
      pulseRise();
      if (sdaOut !== expBit) outErr++;
      if (s == len - 1) begin
        chk("R2 count held until last fall", int'(cntRd), int'(v.cnt));
        chk("R2 no frame end before last fall", int'(ctrlRd[1]), 0);
      end
      pulseFall();
    end
    if (v.tx) chk("R7 transmit bits MSB first", outErr, 0);
    else      chk("R9 receive line drive incl ack slot", outErr, 0);
    chk("R3 count cleared at frame end", int'(cntRd), 0);
    chk("R3 flag set at frame end", int'(ctrlRd[1]), 1);
    chk("R6 irq with flag and enable", int'(irq), 1);
    if (v.tx) expData = (int'(v.data) << n) & 8'hFF;
    else      expData = ((int'(v.data) << n) | (int'(v.rxPat) >> (8 - n))) & 8'hFF;
    if (v.tx) chk("R7 data after transmit", int'(dataRd), expData);
    else      chk("R8 received byte", int'(dataRd), expData);
    if (v.tx && !v.fmt) chk("R10 ack captured", int'(ackSeen), int'(v.ackIn));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 ctrl reset", int'(ctrlRd), 8'h01);
    chk("R1 count reset", int'(cntRd), 0);
    chk("R1 sda released", int'(sdaOut), 1);
    chk("R1 irq low", int'(irq), 0);

    for (int i = 0; i < NVEC; i++) begin
      runVec(vec_t'(VECS[i]));
    end

    // R5: write between frames with SCL low is taken, mid-frame is not
    fmtSync = 1'b0;
    wrCtrl(8'hC0);
    doStart();
    wrCnt(3'd3);
    chk("R5 idle write with SCL low", int'(cntRd), 3);
    sdaIn = 1'b0; tick();
    pulseRise(); pulseFall();
    wrCnt(3'd5);
    chk("R5 mid-frame write ignored", int'(cntRd), 3);

    // R4: start in mid-frame, then stop
    doStart();
    chk("R4 start clears count", int'(cntRd), 0);
    chk("R4 start sets busy", int'(ctrlRd[2]), 1);
    wrCnt(3'd4);
    doStop();
    chk("R4 stop clears busy", int'(ctrlRd[2]), 0);
    chk("R4 stop keeps count", int'(cntRd), 4);
    wrCnt(3'd6);
    chk("R5 nonzero write with SCL high ignored", int'(cntRd), 4);
    wrCnt(3'd0);
    chk("R5 zero write with SCL high taken", int'(cntRd), 0);

    // R6: flag clear only by writing 0
    runVec(vec_t'(VECS[4]));
    wrCtrl(8'h82);
    chk("R6 writing 1 keeps flag", int'(ctrlRd[1]), 1);
    chk("R6 irq masked", int'(irq), 0);
    wrCtrl(8'hC2);
    chk("R6 irq unmasked", int'(irq), 1);
    wrCtrl(8'hC0);
    chk("R6 writing 0 clears flag", int'(ctrlRd[1]), 0);
    chk("R6 irq after clear", int'(irq), 0);

    // R11: disabled block ignores SCL strobes
    wrCtrl(8'h10);
    wrData(8'h55);
    chk("R11 sda released while disabled", int'(sdaOut), 1);
    sdaIn = 1'b0; tick();
    pulseFall(); pulseRise(); pulseFall(); pulseRise(); pulseFall();
    chk("R11 data unchanged", int'(dataRd), 8'h55);
    chk("R11 count unchanged", int'(cntRd), 0);
    chk("R11 sda still released", int'(sdaOut), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule